// File: doc/BRIEF.md
# In-Order Read Return Reorder Buffer

This block sits between a user read port that knows nothing of DRAM banks and a memory-side scheduler that services banks in whatever order suits it. Each accepted read gets a sequence tag from a global request counter. The read is steered into a small queue for its bank, and the queue holds row, column and tag. The scheduler picks one non-empty bank per cycle. The tag of the picked head entry is pushed into a tag queue. Read data comes back from memory in the same order the requests were picked, so the head of the tag queue names the data RAM slot where each returned beat is stored.

The data RAM has one slot per possible tag. Each slot carries a flip bit that toggles on every write. A global delivery counter walks the slots in tag order. A slot counts as fresh when its flip bit differs from the lap bit of the delivery counter. A fresh slot is offered to the user with a valid/ready handshake, and the counter moves on only when the handshake completes. Admission control stops a new request whenever its bank queue is full, or whenever its tag slot still holds data the user has not taken.

Top module: `rd_reorder_buf`

## Requirements
- R1: While reset is applied and in the first cycle after it, `rd_valid` is 0, `bank_pending` is all zeros and `req_ready` is 1.
- R2: An accepted request is queued in the bank named by `req_bank`. Each bank shows its oldest unissued entry on `bank_row[b*ROW_W +: ROW_W]` and `bank_col[b*COL_W +: COL_W]`, with `bank_pending[b]` set while that bank holds entries.
- R3: `req_ready` is 0 whenever the bank named by `req_bank` already holds QDEPTH unissued entries.
- R4: At most NBANK*QDEPTH-1 requests (7 at the defaults) are outstanding, counting from acceptance to delivery. `req_ready` is 0 when that limit is reached.
- R5: The n-th returned beat on `ret_data` belongs to the n-th request issued through `issue_valid`/`issue_bank`, whatever bank that request came from.
- R6: Read data reaches the user in the order the requests were accepted.
- R7: Once `rd_valid` is 1 and `rd_ready` is 0, the next cycle still has `rd_valid` at 1 and the same `rd_data`.
- R8: The delivery position moves by exactly one for each cycle where `rd_valid` and `rd_ready` are both 1, and stays put otherwise.
- R9: An issue request for a bank with no entries, and a returned beat when nothing is outstanding on the memory side, are both ignored. Queue state and user output do not change.
- R10: Data slots are reused on every pass of the tag counter. A slot that has been drained is never offered again until it is written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | User read request valid |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_bank | input | log2(NBANK) | Target bank of the request |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Column address |
| bank_pending | output | NBANK | Bit b set when bank b has an unissued entry |
| bank_row | output | NBANK*ROW_W | Head row of each bank, bank b at b*ROW_W |
| bank_col | output | NBANK*COL_W | Head column of each bank, bank b at b*COL_W |
| issue_valid | input | 1 | Scheduler takes the head of issue_bank this cycle |
| issue_bank | input | log2(NBANK) | Bank whose head is issued |
| ret_valid | input | 1 | Read data beat returned from memory |
| ret_data | input | DATA_W | Returned read data |
| rd_valid | output | 1 | In-order read data available to user |
| rd_ready | input | 1 | User accepts read data |
| rd_data | output | DATA_W | In-order read data |

## Verification
The assertions check the per-cycle invariants on every clock: no push into a full queue, no pop from an empty queue, the outstanding count within its limit, `rd_valid`/`rd_data` held during a stall, and the delivery counter moving only on a handshake. Order restoration across banks (R5, R6), the exact admission points of R3 and R4, the freshness of slots across laps (R10) and the ignored stimulus of R9 can only be shown by the bench. It sweeps several bank patterns and scheduler policies, compares every delivered beat with a value computed from its sequence number, and predicts `req_ready` on every cycle.

// File: rtl/rrob_pkg.sv
`timescale 1ns/1ps
package rrob_pkg;

    // Default configuration of the reorder buffer
    localparam int RROB_NBANK  = 4;
    localparam int RROB_QDEPTH = 2;
    localparam int RROB_ROW_W  = 4;
    localparam int RROB_COL_W  = 3;
    localparam int RROB_DATA_W = 8;

    // A stored slot is fresh when its toggle bit differs from the lap parity
    // of the reader's position.
    function automatic logic slot_fresh(input logic flip, input logic lap);
        return flip ^ lap;
    endfunction

    // Admission test on the low tag bits: the next tag must not land on the
    // slot the reader is still waiting to drain.
    function automatic logic tag_slot_free(input logic [15:0] next_tag,
                                           input logic [15:0] out_tag);
        return next_tag != out_tag;
    endfunction

endpackage

// File: rtl/rrob_fifo.sv
`timescale 1ns/1ps
module rrob_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wptr, rptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (push) wptr <= wptr + 1'b1;
            if (pop)  rptr <= rptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wptr[AW-1:0]] <= din;
    end

    assign dout  = mem[rptr[AW-1:0]];
    assign empty = (wptr == rptr);
    assign full  = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);

    // R3
    no_push_full_chk: assert property (@(posedge clk) disable iff (rst)
        !(push && full));

    // R9
    no_pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
        !(pop && empty));

endmodule

// File: rtl/rrob_slot_ram.sv
`timescale 1ns/1ps
module rrob_slot_ram #(
    parameter int DATA_W = 8,
    parameter int SLOTS  = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [$clog2(SLOTS)-1:0] wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [$clog2(SLOTS)-1:0] rd_addr,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     rd_flip
);
    logic [DATA_W-1:0] data_q [SLOTS];
    logic [SLOTS-1:0]  flip_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flip_q <= '0;
        end else if (wr_en) begin
            flip_q[wr_addr] <= ~flip_q[wr_addr];
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) data_q[wr_addr] <= wr_data;
    end

    assign rd_data = data_q[rd_addr];
    assign rd_flip = flip_q[rd_addr];

endmodule

// File: rtl/rd_reorder_buf.sv
`timescale 1ns/1ps
module rd_reorder_buf
    import rrob_pkg::*;
#(
    parameter int NBANK  = RROB_NBANK,
    parameter int QDEPTH = RROB_QDEPTH,
    parameter int ROW_W  = RROB_ROW_W,
    parameter int COL_W  = RROB_COL_W,
    parameter int DATA_W = RROB_DATA_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [$clog2(NBANK)-1:0]   req_bank,
    input  logic [ROW_W-1:0]           req_row,
    input  logic [COL_W-1:0]           req_col,
    output logic [NBANK-1:0]           bank_pending,
    output logic [NBANK*ROW_W-1:0]     bank_row,
    output logic [NBANK*COL_W-1:0]     bank_col,
    input  logic                       issue_valid,
    input  logic [$clog2(NBANK)-1:0]   issue_bank,
    input  logic                       ret_valid,
    input  logic [DATA_W-1:0]          ret_data,
    output logic                       rd_valid,
    input  logic                       rd_ready,
    output logic [DATA_W-1:0]          rd_data
);
    localparam int BANK_W = $clog2(NBANK);
    localparam int SLOTS  = NBANK * QDEPTH;
    localparam int TAG_W  = $clog2(SLOTS);

    typedef logic [TAG_W:0] seq_t;   // tag plus lap bit

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic [TAG_W-1:0] tag;
    } bank_ent_t;

    localparam int   ENT_W   = $bits(bank_ent_t);
    localparam seq_t MAX_OUT = seq_t'(SLOTS - 1);

    seq_t cmd_in, data_out;

    logic [NBANK-1:0] bank_full, bank_empty, push_b, pop_b;
    logic [TAG_W-1:0] head_tag [NBANK];
    logic             accept, issue_fire, ret_fire, deliver, slot_free;
    logic             tq_empty, tq_full, rd_flip;
    logic [TAG_W-1:0] tq_head, next_tag;

    // ---------------- admission and tagging ----------------
    assign next_tag  = cmd_in[TAG_W-1:0] + 1'b1;
    assign slot_free = tag_slot_free(16'(next_tag), 16'(data_out[TAG_W-1:0]));
    assign req_ready = slot_free && !bank_full[req_bank];
    assign accept    = req_valid && req_ready;

    // ---------------- per-bank queues ----------------
    assign issue_fire = issue_valid && !bank_empty[issue_bank];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        bank_ent_t ent_in, ent_out;

        assign ent_in  = '{row: req_row, col: req_col, tag: cmd_in[TAG_W-1:0]};
        assign push_b[b] = accept && (req_bank == BANK_W'(b));
        assign pop_b[b]  = issue_fire && (issue_bank == BANK_W'(b));

        rrob_fifo #(.W(ENT_W), .DEPTH(QDEPTH)) u_bank_q (
            .clk   (clk),
            .rst   (rst),
            .push  (push_b[b]),
            .din   (ent_in),
            .pop   (pop_b[b]),
            .dout  (ent_out),
            .empty (bank_empty[b]),
            .full  (bank_full[b])
        );

        assign bank_row[b*ROW_W +: ROW_W] = ent_out.row;
        assign bank_col[b*COL_W +: COL_W] = ent_out.col;
        assign head_tag[b]                = ent_out.tag;
    end

    assign bank_pending = ~bank_empty;

    // ---------------- issue-order tag queue ----------------
    assign ret_fire = ret_valid && !tq_empty;

    rrob_fifo #(.W(TAG_W), .DEPTH(SLOTS)) u_tag_q (
        .clk   (clk),
        .rst   (rst),
        .push  (issue_fire),
        .din   (head_tag[issue_bank]),
        .pop   (ret_fire),
        .dout  (tq_head),
        .empty (tq_empty),
        .full  (tq_full)
    );

    // ---------------- data slots with toggle bits ----------------
    rrob_slot_ram #(.DATA_W(DATA_W), .SLOTS(SLOTS)) u_slots (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (ret_fire),
        .wr_addr (tq_head),
        .wr_data (ret_data),
        .rd_addr (data_out[TAG_W-1:0]),
        .rd_data (rd_data),
        .rd_flip (rd_flip)
    );

    assign rd_valid = slot_fresh(rd_flip, data_out[TAG_W]);
    assign deliver  = rd_valid && rd_ready;

    // ---------------- sequence counters ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_in   <= '0;
            data_out <= '0;
        end else begin
            if (accept)  cmd_in   <= cmd_in + 1'b1;
            if (deliver) data_out <= data_out + 1'b1;
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rd_valid && (bank_pending == '0) && req_ready));

    // R4
    outstanding_limit_chk: assert property (@(posedge clk) disable iff (rst)
        seq_t'(cmd_in - data_out) <= MAX_OUT);

    // R4
    tag_queue_room_chk: assert property (@(posedge clk) disable iff (rst)
        !(tq_full && issue_fire));

    // R7
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

    // R8
    out_still_chk: assert property (@(posedge clk) disable iff (rst)
        !(rd_valid && rd_ready) |=> $stable(data_out));

    // R8
    out_step_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_ready) |=> (data_out == seq_t'($past(data_out) + 1'b1)));

endmodule

// File: tb/rd_reorder_buf_tb.sv
`timescale 1ns/1ps
module rd_reorder_buf_tb;

    localparam int NB = 4;
    localparam int QD = 2;
    localparam int MAXO = NB * QD - 1;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_ready;
    logic [1:0]  req_bank;
    logic [3:0]  req_row;
    logic [2:0]  req_col;
    logic [3:0]  bank_pending;
    logic [15:0] bank_row;
    logic [11:0] bank_col;
    logic        issue_valid;
    logic [1:0]  issue_bank;
    logic        ret_valid;
    logic [7:0]  ret_data;
    logic        rd_valid, rd_ready;
    logic [7:0]  rd_data;

    always #2.5 clk = ~clk;

    rd_reorder_buf u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_bank(req_bank),
        .req_row(req_row), .req_col(req_col),
        .bank_pending(bank_pending), .bank_row(bank_row), .bank_col(bank_col),
        .issue_valid(issue_valid), .issue_bank(issue_bank),
        .ret_valid(ret_valid), .ret_data(ret_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // bench model state
    logic [7:0] exp_data [0:4095];
    int         bq [NB][0:4095];
    int         bq_h [NB];
    int         bq_t [NB];
    logic [7:0] retq [0:4095];
    int         rq_h, rq_t;
    int         acc_cnt, dlv_cnt;
    logic [15:0] lfsr = 16'hACE1;

    function automatic logic [7:0] mkdata(input int id);
        logic [15:0] v;
        v = 16'(id);
        return {v[3:0], v[6:4], v[7]};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle_inputs();
        req_valid = 0; req_bank = 0; req_row = 0; req_col = 0;
        issue_valid = 0; issue_bank = 0; ret_valid = 0; ret_data = 0; rd_ready = 0;
    endtask

    task automatic reset_all();
        idle_inputs();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int b = 0; b < NB; b++) begin bq_h[b] = 0; bq_t[b] = 0; end
        rq_h = 0; rq_t = 0; acc_cnt = 0; dlv_cnt = 0;
    endtask

    task automatic push_direct(input logic [1:0] b, input logic [3:0] r, input logic [2:0] c);
        @(negedge clk);
        req_valid = 1; req_bank = b; req_row = r; req_col = c;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
    endtask

    // Traffic run: policy picks bank pattern, scheduler order and stalls.
    task automatic run(input int n_req, input int policy);
        int  target, pb, start, b, id;
        bit  hold_prev;
        logic [7:0] hold_data;
        target = acc_cnt + n_req;
        hold_prev = 0;
        hold_data = 0;
        while (dlv_cnt < target) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            // request side
            req_valid = (acc_cnt < target);
            case (policy)
                0:       req_bank = 2'(acc_cnt % 4);
                1:       req_bank = 2'((acc_cnt / 3) % 4);
                default: req_bank = lfsr[9:8];
            endcase
            req_row = 4'(acc_cnt);
            req_col = 3'(acc_cnt >> 4);
            // scheduler side
            pb = -1;
            if (policy == 0) begin
                for (int i = 0; i < NB; i++) if (bank_pending[i]) pb = i;
            end else if (policy == 1) begin
                for (int i = NB - 1; i >= 0; i--) if (bank_pending[i]) pb = i;
            end else begin
                start = int'(lfsr[1:0]);
                for (int i = 0; i < NB; i++) begin
                    int j;
                    j = (start + i) % NB;
                    if (bank_pending[j] && pb < 0) pb = j;
                end
            end
            issue_valid = (pb >= 0) && (policy != 3 || lfsr[3]);
            issue_bank  = (pb >= 0) ? 2'(pb) : 2'd0;
            // memory return side
            ret_valid = (rq_h != rq_t) && (policy == 0 || lfsr[5:4] != 2'b00);
            ret_data  = ret_valid ? retq[rq_h] : 8'h00;
            // user side
            rd_ready = (policy == 3) ? lfsr[7] : (lfsr[6] | lfsr[11]);
            #1;
            // R7: a stalled beat must still be there with the same value
            if (hold_prev) begin
                chk(rd_valid == 1'b1, "R7 valid held", int'(rd_valid), 1);
                chk(rd_data == hold_data, "R7 data held", int'(rd_data), int'(hold_data));
            end
            // R3 R4: predicted admission
            if (req_valid) begin
                bit exp_rdy;
                b = int'(req_bank);
                exp_rdy = ((acc_cnt - dlv_cnt) < MAXO) && ((bq_t[b] - bq_h[b]) < QD);
                chk(req_ready == exp_rdy, "R3 R4 req_ready", int'(req_ready), int'(exp_rdy));
            end
            // issue bookkeeping, R2 head check
            if (issue_valid) begin
                b  = pb;
                id = bq[b][bq_h[b]];
                chk(bank_row[b*4 +: 4] == 4'(id), "R2 head row", int'(bank_row[b*4 +: 4]), id % 16);
                chk(bank_col[b*3 +: 3] == 3'(id >> 4), "R2 head col", int'(bank_col[b*3 +: 3]), (id >> 4) % 8);
                retq[rq_t] = mkdata(id);
                rq_t++;
                bq_h[b]++;
            end
            if (ret_valid) rq_h++;
            // acceptance
            if (req_valid && req_ready) begin
                b = int'(req_bank);
                exp_data[acc_cnt] = mkdata(acc_cnt);
                bq[b][bq_t[b]] = acc_cnt;
                bq_t[b]++;
                acc_cnt++;
            end
            // delivery: R5 R6 R8 order check
            if (rd_valid && rd_ready) begin
                chk(rd_data == exp_data[dlv_cnt], "R5 R6 R8 in-order data",
                    int'(rd_data), int'(exp_data[dlv_cnt]));
                dlv_cnt++;
            end
            hold_prev = rd_valid && !rd_ready;
            hold_data = rd_data;
        end
        // R10: drained slots are not offered again
        @(negedge clk);
        idle_inputs();
        rd_ready = 1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(rd_valid == 1'b0, "R10 drained slot stale", int'(rd_valid), 0);
        end
        rd_ready = 0;
    endtask

    initial begin
        reset_all();
        // R1: state right after reset
        #1;
        chk(rd_valid == 1'b0, "R1 rd_valid", int'(rd_valid), 0);
        chk(bank_pending == 4'b0000, "R1 bank_pending", int'(bank_pending), 0);
        chk(req_ready == 1'b1, "R1 req_ready", int'(req_ready), 1);

        // R3 and R2: fill bank 0
        push_direct(2'd0, 4'd3, 3'd1);
        push_direct(2'd0, 4'd5, 3'd2);
        req_valid = 1; req_bank = 2'd0; #1;
        chk(req_ready == 1'b0, "R3 bank 0 full", int'(req_ready), 0);
        chk(bank_pending == 4'b0001, "R2 pending mask", int'(bank_pending), 1);
        chk(bank_row[3:0] == 4'd3, "R2 head row", int'(bank_row[3:0]), 3);
        chk(bank_col[2:0] == 3'd1, "R2 head col", int'(bank_col[2:0]), 1);
        req_bank = 2'd1; #1;
        chk(req_ready == 1'b1, "R3 other bank open", int'(req_ready), 1);
        req_valid = 0;

        // R4: seven outstanding blocks an open bank
        push_direct(2'd1, 4'd1, 3'd0);
        push_direct(2'd1, 4'd2, 3'd0);
        push_direct(2'd2, 4'd4, 3'd0);
        push_direct(2'd2, 4'd6, 3'd0);
        push_direct(2'd3, 4'd7, 3'd0);
        req_valid = 1; req_bank = 2'd3; #1;
        chk(req_ready == 1'b0, "R4 outstanding limit", int'(req_ready), 0);
        chk(bank_pending == 4'b1111, "R2 all banks pending", int'(bank_pending), 15);
        req_valid = 0;

        // R9: empty-bank issue and unsolicited return are ignored
        reset_all();
        issue_valid = 1; issue_bank = 2'd1; ret_valid = 1; ret_data = 8'hA5; rd_ready = 1;
        @(negedge clk);
        idle_inputs();
        rd_ready = 1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(rd_valid == 1'b0, "R9 no spurious data", int'(rd_valid), 0);
            chk(bank_pending == 4'b0000, "R9 queues untouched", int'(bank_pending), 0);
        end

        // Sweeps over bank patterns and scheduler policies (R5 R6 R10 laps)
        run(20, 0);
        for (int p = 0; p < 4; p++) run(400, p);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", dlv_cnt, acc_cnt);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule